// File: doc/BRIEF.md
# Ordered Bus-Protection Step Sequencer

This block raises or drops a chain of bus-protection steps around a power-domain transition. Each step owns one bit of a protection group. A step is raised by a single-cycle, one-hot pulse on the set strobe vector and dropped by the same kind of pulse on the clear strobe vector. The interconnect answers each step through a per-bit ready input.

A one-cycle start pulse launches a walk, and a mode input chosen with it selects protect or release. A protect walk goes upward from step 0. After each set pulse it polls that step's ready bit at a fixed interval, up to a fixed number of polls. A release walk goes downward from the last step, pulsing one clear strobe per cycle without looking at ready. If a protect step's poll budget runs out, the block pulses the clear strobe of that same step and abandons the walk with an error pulse. A clean walk ends with a done pulse.

The step count, the poll interval in cycles and the poll budget are parameters. The defaults are sized for a budget of ten thousand polls spaced ten microseconds apart at 125 MHz.

Top module: `bprot_seq`

## Requirements
- R1: While reset is asserted, and after it until a start is accepted, both strobe vectors are zero and busy, done and error are low.
- R2: A start with the mode input at 1 (protect) pulses the set strobe of steps 0, 1, ..., N-1 in that order. Each pulse lasts one cycle and has one bit high, at the step's index.
- R3: A start with the mode input at 0 (release) pulses the clear strobe of steps N-1 down to 0 on consecutive cycles, with no ready wait. The first pulse comes in the cycle after the start is sampled.
- R4: After a set pulse in cycle c, that step's ready bit is sampled at the end of cycles c+G, c+2G, and so on, up to c+L*G, where G is the poll interval and L is the poll budget. The next step's set pulse comes in the cycle after the first sample that reads 1.
- R5: While a protect walk polls a step, the ready bits of all other steps have no effect.
- R6: If all L samples of a step read 0, the clear strobe of that same step pulses in the next cycle and error pulses in the cycle after that. No later step is strobed.
- R7: Done pulses for one cycle. In a protect walk it comes in the cycle after the last step's successful sample. In a release walk it comes in the cycle after the step-0 clear pulse. Done and error are never high together.
- R8: Busy is high from the first strobe cycle through the done or error cycle. A start pulse while busy is ignored.
- R9: The two strobe vectors are never non-zero in the same cycle, and each has at most one bit high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a walk, sampled when idle |
| protect_i | input | 1 | Walk mode sampled with start: 1 protect, 0 release |
| ready_i | input | NUM_STEPS | Per-step protection-ready status from the interconnect |
| set_stb_o | output | NUM_STEPS | One-hot write-one-to-set strobe |
| clr_stb_o | output | NUM_STEPS | One-hot write-one-to-clear strobe |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle pulse on successful completion |
| err_o | output | 1 | One-cycle pulse after a rolled-back timeout |

## Verification
The timing in this block follows from the start cycle. The first strobe is due one cycle after the start is sampled. A protect step's samples fall exactly G, 2G, ... cycles after its set pulse, and the next pulse follows one cycle after a successful sample. Release pulses come back to back, and the done or error pulse follows one cycle after the final strobe or rollback. A procedural reference model in the bench replays these waits with plain cycle counts and reads the same ready inputs. All five outputs are compared with the model at every falling edge, so an early or late strobe is caught in the exact cycle it deviates. Latencies of 12 and 13 cycles against a 4-poll, 3-cycle budget probe the boundary of R4 and R6, and recorded strobe-index queues confirm the walk order.

// File: rtl/bprot_pkg.sv
package bprot_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_STROBE = 3'd1,
      ST_POLL   = 3'd2,
      ST_UNDO   = 3'd3,
      ST_DONE   = 3'd4,
      ST_FAIL   = 3'd5
   } bprot_state_e;

endpackage

// File: rtl/bprot_step_ptr.sv
module bprot_step_ptr #(
   parameter int NUM_STEPS = 8,
   localparam int IW = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          load_up_i,
   input  logic          step_i,
   output logic [IW-1:0] idx_o,
   output logic          up_o,
   output logic          at_end_o
);

   localparam logic [IW-1:0] LAST_IDX = IW'(NUM_STEPS - 1);

   logic [IW-1:0] idx_q;
   logic          up_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         up_q  <= 1'b0;
      end else if (load_i) begin
         up_q  <= load_up_i;
         idx_q <= load_up_i ? '0 : LAST_IDX;
      end else if (step_i) begin
         idx_q <= up_q ? idx_q + IW'(1) : idx_q - IW'(1);
      end
   end

   assign idx_o    = idx_q;
   assign up_o     = up_q;
   assign at_end_o = up_q ? (idx_q == LAST_IDX) : (idx_q == '0);

   // R2 R3: the pointer never leaves the step range
   a_r2_idx_in_range : assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= LAST_IDX);

endmodule

// File: rtl/bprot_poll_timer.sv
module bprot_poll_timer #(
   parameter int POLL_GAP   = 1250,
   parameter int POLL_LIMIT = 10000,
   localparam int GW = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1,
   localparam int PW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic run_i,
   output logic poll_o,
   output logic last_o
);

   localparam logic [PW-1:0] LAST_POLL = PW'(POLL_LIMIT - 1);

   logic [PW-1:0] polls_q;
   logic          tick;

   generate
      if (POLL_GAP > 1) begin : g_gap
         logic [GW-1:0] gap_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               gap_q <= '0;
            else if (arm_i || (run_i && gap_q == '0))
               gap_q <= GW'(POLL_GAP - 1);
            else if (run_i)
               gap_q <= gap_q - GW'(1);
         end
         assign tick = (gap_q == '0);
      end else begin : g_nogap
         assign tick = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         polls_q <= '0;
      else if (arm_i)
         polls_q <= '0;
      else if (run_i && tick && polls_q != LAST_POLL)
         polls_q <= polls_q + PW'(1);
   end

   assign poll_o = run_i && tick;
   assign last_o = (polls_q == LAST_POLL);

   // R6: the spent-poll count never passes the budget
   a_r6_poll_bound : assert property (@(posedge clk) disable iff (!rst_n)
      polls_q <= LAST_POLL);

endmodule

// File: rtl/bprot_strobe_drv.sv
module bprot_strobe_drv #(
   parameter int NUM_STEPS = 8,
   localparam int IW = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1
) (
   input  logic [IW-1:0]        idx_i,
   input  logic                 fire_set_i,
   input  logic                 fire_clr_i,
   input  logic [NUM_STEPS-1:0] ready_i,
   output logic [NUM_STEPS-1:0] set_stb_o,
   output logic [NUM_STEPS-1:0] clr_stb_o,
   output logic                 hit_o
);

   logic [NUM_STEPS-1:0] sel;

   generate
      for (genvar b = 0; b < NUM_STEPS; b++) begin : g_bit
         assign sel[b]       = (idx_i == IW'(b));
         assign set_stb_o[b] = fire_set_i && sel[b];
         assign clr_stb_o[b] = fire_clr_i && sel[b];
      end
   endgenerate

   // R5: only the addressed step's ready bit reaches the sequencer
   assign hit_o = |(ready_i & sel);

endmodule

// File: rtl/bprot_seq.sv
module bprot_seq #(
   parameter int NUM_STEPS  = 8,
   parameter int POLL_GAP   = 1250,
   parameter int POLL_LIMIT = 10000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic                 protect_i,
   input  logic [NUM_STEPS-1:0] ready_i,
   output logic [NUM_STEPS-1:0] set_stb_o,
   output logic [NUM_STEPS-1:0] clr_stb_o,
   output logic                 busy_o,
   output logic                 done_o,
   output logic                 err_o
);

   import bprot_pkg::*;

   localparam int IW = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1;

   generate
      if (NUM_STEPS < 1) begin : g_bad_steps
         $error("bprot_seq: NUM_STEPS must be at least 1");
      end
      if (POLL_GAP < 1) begin : g_bad_gap
         $error("bprot_seq: POLL_GAP must be at least 1");
      end
      if (POLL_LIMIT < 1) begin : g_bad_limit
         $error("bprot_seq: POLL_LIMIT must be at least 1");
      end
   endgenerate

   bprot_state_e state_q, state_d;

   logic [IW-1:0] idx;
   logic          up, at_end, hit, poll, last;
   logic          ld, stp, arm, run, fire_set, fire_clr;

   always_comb begin
      state_d  = state_q;
      ld       = 1'b0;
      stp      = 1'b0;
      arm      = 1'b0;
      run      = 1'b0;
      fire_set = 1'b0;
      fire_clr = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               ld      = 1'b1;
               state_d = ST_STROBE;
            end
         end
         ST_STROBE: begin
            if (up) begin
               fire_set = 1'b1;
               arm      = 1'b1;
               state_d  = ST_POLL;
            end else begin
               fire_clr = 1'b1;
               if (at_end) state_d = ST_DONE;
               else        stp     = 1'b1;
            end
         end
         ST_POLL: begin
            run = 1'b1;
            if (poll) begin
               if (hit) begin
                  if (at_end) state_d = ST_DONE;
                  else begin
                     stp     = 1'b1;
                     state_d = ST_STROBE;
                  end
               end else if (last) begin
                  state_d = ST_UNDO;
               end
            end
         end
         ST_UNDO: begin
            fire_clr = 1'b1;
            state_d  = ST_FAIL;
         end
         ST_DONE: state_d = ST_IDLE;
         ST_FAIL: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   bprot_step_ptr #(.NUM_STEPS(NUM_STEPS)) u_ptr (
      .clk(clk), .rst_n(rst_n), .load_i(ld), .load_up_i(protect_i),
      .step_i(stp), .idx_o(idx), .up_o(up), .at_end_o(at_end));

   bprot_poll_timer #(.POLL_GAP(POLL_GAP), .POLL_LIMIT(POLL_LIMIT)) u_timer (
      .clk(clk), .rst_n(rst_n), .arm_i(arm), .run_i(run),
      .poll_o(poll), .last_o(last));

   bprot_strobe_drv #(.NUM_STEPS(NUM_STEPS)) u_drv (
      .idx_i(idx), .fire_set_i(fire_set), .fire_clr_i(fire_clr),
      .ready_i(ready_i), .set_stb_o(set_stb_o), .clr_stb_o(clr_stb_o),
      .hit_o(hit));

   assign busy_o = (state_q != ST_IDLE);
   assign done_o = (state_q == ST_DONE);
   assign err_o  = (state_q == ST_FAIL);

   a_r9_set_onehot : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(set_stb_o));
   a_r9_clr_onehot : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_stb_o));
   a_r9_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
      !((|set_stb_o) && (|clr_stb_o)));
   a_r4_set_then_wait : assert property (@(posedge clk) disable iff (!rst_n)
      (|set_stb_o) |=> (set_stb_o == '0) && (clr_stb_o == '0) && busy_o);
   a_r6_err_after_undo : assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(|clr_stb_o));
   a_r7_done_single : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o && !err_o);
   a_r7_done_err_apart : assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));
   a_r8_busy_with_strobe : assert property (@(posedge clk) disable iff (!rst_n)
      ((|set_stb_o) || (|clr_stb_o)) |-> busy_o);

endmodule

// File: tb/bprot_seq_tb.sv
module bprot_seq_tb;

   localparam int NS = 5;
   localparam int PG = 3;
   localparam int PL = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic protect_i = 1'b0;
   logic [NS-1:0] rdy_r = '0;
   logic [NS-1:0] hold_mask = '0;
   logic [NS-1:0] ready_i;
   logic [NS-1:0] set_stb_o, clr_stb_o;
   logic busy_o, done_o, err_o;

   assign ready_i = rdy_r | hold_mask;

   always #4 clk = ~clk;

   bprot_seq #(.NUM_STEPS(NS), .POLL_GAP(PG), .POLL_LIMIT(PL)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .protect_i(protect_i),
      .ready_i(ready_i), .set_stb_o(set_stb_o), .clr_stb_o(clr_stb_o),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

   int checks = 0;
   int errors = 0;

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
      end
   endtask

   // ---------------- responder: ready follows strobes after a latency
   int lat [NS];
   logic [NS-1:0] never_mask = '0;
   int cnt [NS];
   bit pend [NS];
   bit tgt [NS];

   always @(negedge clk) begin
      for (int b = 0; b < NS; b++) begin
         if (set_stb_o[b] || clr_stb_o[b]) begin
            tgt[b] = set_stb_o[b];
            if (lat[b] == 0) begin
               rdy_r[b] <= tgt[b] && !never_mask[b];
               pend[b] = 0;
            end else begin
               cnt[b] = lat[b];
               pend[b] = 1;
            end
         end else if (pend[b]) begin
            cnt[b]--;
            if (cnt[b] == 0) begin
               rdy_r[b] <= tgt[b] && !never_mask[b];
               pend[b] = 0;
            end
         end
      end
   end

   // ---------------- reference model
   logic [NS-1:0] exp_set = '0, exp_clr = '0;
   bit exp_busy = 0, exp_done = 0, exp_err = 0;

   initial begin
      bit hit, ok_all;
      wait (rst_n);
      forever begin
         @(posedge clk);
         if (start_i) begin
            if (protect_i) begin
               ok_all = 1;
               for (int i = 0; i < NS; i++) begin
                  exp_busy = 1;
                  exp_set = NS'(1) << i;
                  @(posedge clk);
                  exp_set = '0;
                  hit = 0;
                  for (int p = 0; p < PL && !hit; p++) begin
                     repeat (PG) @(posedge clk);
                     if (ready_i[i]) hit = 1;
                  end
                  if (!hit) begin
                     exp_clr = NS'(1) << i;
                     @(posedge clk);
                     exp_clr = '0;
                     exp_err = 1;
                     @(posedge clk);
                     exp_err = 0;
                     exp_busy = 0;
                     ok_all = 0;
                     break;
                  end
               end
               if (ok_all) begin
                  exp_done = 1;
                  @(posedge clk);
                  exp_done = 0;
                  exp_busy = 0;
               end
            end else begin
               for (int i = NS - 1; i >= 0; i--) begin
                  exp_busy = 1;
                  exp_clr = NS'(1) << i;
                  @(posedge clk);
                  exp_clr = '0;
               end
               exp_done = 1;
               @(posedge clk);
               exp_done = 0;
               exp_busy = 0;
            end
         end
      end
   end

   // ---------------- per-cycle compare and event recording
   int set_q[$];
   int clr_q[$];
   int done_cnt = 0, err_cnt = 0;

   always @(negedge clk) begin
      check(set_stb_o == exp_set, "R2 R4 set strobe", int'(set_stb_o), int'(exp_set));
      check(clr_stb_o == exp_clr, "R3 R6 clear strobe", int'(clr_stb_o), int'(exp_clr));
      check(busy_o == exp_busy, "R8 busy", int'(busy_o), int'(exp_busy));
      check(done_o == exp_done, "R7 done", int'(done_o), int'(exp_done));
      check(err_o == exp_err, "R6 error", int'(err_o), int'(exp_err));
      check(!((|set_stb_o) && (|clr_stb_o)), "R9 exclusive strobes", int'(set_stb_o), 0);
      for (int b = 0; b < NS; b++) begin
         if (set_stb_o[b]) set_q.push_back(b);
         if (clr_stb_o[b]) clr_q.push_back(b);
      end
      if (done_o) done_cnt++;
      if (err_o) err_cnt++;
   end

   // ---------------- watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // ---------------- stimulus helpers
   task automatic clear_env();
      @(negedge clk);
      for (int b = 0; b < NS; b++) begin
         lat[b] = 0;
         pend[b] = 0;
      end
      rdy_r = '0;
      never_mask = '0;
      hold_mask = '0;
      set_q.delete();
      clr_q.delete();
      done_cnt = 0;
      err_cnt = 0;
   endtask

   task automatic walk(input bit prot, input int poke_at);
      @(negedge clk);
      start_i = 1'b1;
      protect_i = prot;
      @(negedge clk);
      start_i = 1'b0;
      for (int k = 1; k < 400; k++) begin
         if (k == poke_at) begin
            start_i = 1'b1;
            protect_i = ~prot;
         end else begin
            start_i = 1'b0;
         end
         if (!busy_o && k > 1) break;
         @(negedge clk);
      end
      start_i = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic check_order(input int q[$], input int expq[$], input string tag);
      check(q.size() == expq.size(), tag, q.size(), expq.size());
      for (int i = 0; i < expq.size() && i < q.size(); i++)
         check(q[i] == expq[i], tag, q[i], expq[i]);
   endtask

   initial begin
      for (int b = 0; b < NS; b++) begin
         lat[b] = 0;
         cnt[b] = 0;
         pend[b] = 0;
         tgt[b] = 0;
      end
      // R1: outputs quiet during and after reset
      repeat (3) @(negedge clk);
      check(set_stb_o == '0 && clr_stb_o == '0, "R1 strobes in reset", int'(set_stb_o | clr_stb_o), 0);
      check(!busy_o && !done_o && !err_o, "R1 flags in reset", int'({busy_o, done_o, err_o}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(!busy_o && set_stb_o == '0, "R1 idle after reset", int'(busy_o), 0);

      // R2 R7: protect walk, immediate ready
      clear_env();
      walk(1'b1, 0);
      check_order(set_q, '{0, 1, 2, 3, 4}, "R2 protect order");
      check(clr_q.size() == 0, "R2 no clear strobes", clr_q.size(), 0);
      check(done_cnt == 1 && err_cnt == 0, "R7 one done", done_cnt, 1);

      // R3: release walk goes downward
      set_q.delete(); clr_q.delete(); done_cnt = 0;
      walk(1'b0, 0);
      check_order(clr_q, '{4, 3, 2, 1, 0}, "R3 release order");
      check(set_q.size() == 0, "R3 no set strobes", set_q.size(), 0);
      check(done_cnt == 1, "R7 release done", done_cnt, 1);

      // R8 R4: slow ready, second poll, start poked while busy
      clear_env();
      for (int b = 0; b < NS; b++) lat[b] = 5;
      walk(1'b1, 9);
      check(done_cnt == 1 && err_cnt == 0, "R8 poke ignored", done_cnt, 1);
      check(clr_q.size() == 0, "R8 no release from poke", clr_q.size(), 0);

      // R4: ready lands on the very last poll
      clear_env();
      for (int b = 0; b < NS; b++) lat[b] = PG * PL;
      walk(1'b1, 0);
      check(done_cnt == 1 && err_cnt == 0, "R4 last poll accepted", err_cnt, 0);
      check(set_q.size() == NS, "R4 all steps", set_q.size(), NS);

      // R6: one cycle too slow on step 1 -> rollback of step 1
      clear_env();
      lat[1] = PG * PL + 1;
      walk(1'b1, 0);
      check(err_cnt == 1 && done_cnt == 0, "R6 timeout error", err_cnt, 1);
      check_order(set_q, '{0, 1}, "R6 walk stops");
      check_order(clr_q, '{1}, "R6 rollback same step");

      // R5: step 2 never ready while later steps already show ready
      clear_env();
      never_mask[2] = 1'b1;
      hold_mask = 5'b11000;
      walk(1'b1, 0);
      check(err_cnt == 1, "R5 other ready ignored", err_cnt, 1);
      check_order(clr_q, '{2}, "R5 rollback step 2");
      check(set_q.size() == 3, "R5 no later steps", set_q.size(), 3);

      // release after a failed walk still completes
      set_q.delete(); clr_q.delete(); done_cnt = 0; err_cnt = 0;
      hold_mask = '0;
      walk(1'b0, 0);
      check(done_cnt == 1, "R3 release after failure", done_cnt, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule